// File: doc/BRIEF.md
# UART line status with FIFOs

This block is the character-buffering and status core of a memory-mapped serial port. It keeps two 128-entry queues: one feeds the transmit shifter, the other collects characters from the receive shifter. Each received character travels through its queue together with the error conditions seen while it was received. A status byte combines the fill state of both queues, an all-quiet flag for the transmitter and the error conditions of the oldest unread received character. Software reaches the block through one-cycle read and write strobes and a two-bit word address. The shifters and the baud timing are not part of the block. They appear as strobed ports: a take strobe and an idle level on the transmit side, and a store strobe carrying the character and its error flags on the receive side.

The word address selects one of four locations. 0 is the data port: a write queues a character for transmission and a read takes the oldest received character. 1 is the read-only status byte. 2 is the line control byte. 3 is the receive flush location, which is write-only. Bit 5 of line control forces the serial output into the break (low) state. While bit 5 is clear, the serial output follows the shifter's bit stream one cycle later.

Top module: `uart_lsr_top`

## Requirements
- R1: After reset both queues are empty, a status read returns 8'h41 while `tx_idle` is 1, line control reads 0 and `ser_out` follows `ser_in` with one cycle of delay.
- R2: A write to address 0 appends `bus_wdata` to the transmit queue. `tx_data` shows the oldest queued character while `tx_avail` is 1, and `tx_take` removes it. The queue holds 128 characters. Status bit 0 (room to transmit) is 1 exactly when fewer than 128 are queued.
- R3: A write to address 0 while the transmit queue holds 128 characters is dropped, and the queue contents and their order are unchanged.
- R4: Status bit 6 (transmitter drained) is 1 only when the transmit queue is empty and `tx_idle` is 1.
- R5: A `rx_stb` pulse stores `rx_char` with its flags. A read of address 0 returns the oldest stored character and removes it. Status bit 1 is 1 while any character is stored. A read of address 0 with nothing stored returns 0 and changes nothing.
- R6: Status bits 5 (break), 4 (framing), 3 (overrun) and 2 (parity) describe the oldest stored character and move to the next character when that one is read. With nothing stored these bits are 0.
- R7: When the oldest character carries the break flag, status bits 4 and 2 read 0 whatever framing and parity flags it was stored with.
- R8: A character strobed in while 128 are stored is lost. The next character that is stored carries the overrun flag (status bit 3).
- R9: Writing 0 to address 3 empties the receive queue and cancels a pending overrun. A write of any other value to address 3 has no effect. If a flush and `rx_stb` fall in the same cycle, the incoming character is discarded.
- R10: Line control is a readable byte at address 2. While its bit 5 is 1, `ser_out` is 0 from the cycle after the bit is set until one cycle after it is cleared.
- R11: `bus_rdata` is a register. It updates on the clock edge that samples `bus_rd` and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 2 | Word address: 0 data, 1 status, 2 line control, 3 receive flush |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tx_data | output | 8 | Oldest character in the transmit queue |
| tx_avail | output | 1 | Transmit queue not empty |
| tx_take | input | 1 | Shifter takes `tx_data` |
| tx_idle | input | 1 | Transmit shifter has nothing in flight |
| ser_in | input | 1 | Serial bit stream from the transmit shifter |
| ser_out | output | 1 | Serial line output, forced low in break |
| rx_stb | input | 1 | Receive shifter delivers a character |
| rx_char | input | 8 | Received character |
| rx_perr | input | 1 | Parity error seen on this character |
| rx_ferr | input | 1 | Framing error seen on this character |
| rx_brk | input | 1 | Line break seen on this character |

## Verification
The following properties are checked on every cycle:
- A write to a full transmit queue leaves its level unchanged.
- A zero write to the flush location leaves the receive queue empty.
- A status byte never shows break together with a framing or parity bit.
- The drained bit stays low while characters are queued.
- Break in line control holds the line low.
- Neither queue level exceeds its depth.

Other behaviour can only be shown by the bench's scenarios, because it depends on history that spans many accesses:
- Characters keep their order through both queues.
- The overrun flag lands on the character after the lost one, and a flush cancels it.
- The error flags follow the head of the receive queue as it is read.
- A nonzero write to the flush location is ignored.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;

  localparam int CHAR_W = 8;
  localparam int ADDR_W = 2;

  // word addresses seen by software
  localparam logic [ADDR_W-1:0] ADR_DATA  = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_STAT  = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_LCTL  = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_FLUSH = 2'd3;

  // status byte bit positions (decoded by software)
  localparam int ST_TX_ROOM  = 0;
  localparam int ST_RX_AVAIL = 1;
  localparam int ST_PAR      = 2;
  localparam int ST_OVR      = 3;
  localparam int ST_FRM      = 4;
  localparam int ST_BRK      = 5;
  localparam int ST_TX_DONE  = 6;

  // line control bit that forces the line low
  localparam int LC_FORCE_BRK = 5;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic              ovr;
    logic [CHAR_W-1:0] ch;
  } rx_ent_t;

endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] level
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == FULL_CNT);
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign level   = cnt;
  assign dout    = mem[rp];

  // storage array: write port only, no reset, so it maps to RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      unique case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/uart_rx_path.sv
module uart_rx_path
  import uart_lsr_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_stb,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  input  logic              rx_brk,
  input  logic              flush,
  input  logic              pop,
  output rx_ent_t           head,
  output logic              empty,
  output logic [CW-1:0]     level
);

  localparam int EW = $bits(rx_ent_t);

  logic          ovr_pend;
  logic          full;
  logic          store;
  rx_ent_t       ent;
  logic [EW-1:0] dout;

  // a flush discards anything arriving in the same cycle
  assign store = rx_stb && !flush && !full;

  assign ent = '{brk: rx_brk, frm: rx_ferr, par: rx_perr, ovr: ovr_pend, ch: rx_char};

  always_ff @(posedge clk) begin
    if (rst || flush)       ovr_pend <= 1'b0;
    else if (rx_stb && full) ovr_pend <= 1'b1;
    else if (store)          ovr_pend <= 1'b0;
  end

  uart_fifo #(.W(EW), .DEPTH(DEPTH)) u_rxq (
    .clk   (clk),
    .rst   (rst),
    .clr   (flush),
    .push  (store),
    .pop   (pop && !flush),
    .din   (ent),
    .dout  (dout),
    .empty (empty),
    .full  (full),
    .level (level)
  );

  assign head = dout;

endmodule

// File: rtl/uart_lsr_top.sv
module uart_lsr_top
  import uart_lsr_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CHAR_W-1:0] bus_wdata,
  output logic [CHAR_W-1:0] bus_rdata,
  output logic [CHAR_W-1:0] tx_data,
  output logic              tx_avail,
  input  logic              tx_take,
  input  logic              tx_idle,
  input  logic              ser_in,
  output logic              ser_out,
  input  logic              rx_stb,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  input  logic              rx_brk
);

  localparam int CW = $clog2(DEPTH) + 1;

  logic              tx_empty, tx_full;
  logic [CW-1:0]     tx_lvl, rx_lvl;
  logic              rx_empty;
  rx_ent_t           rx_head;
  logic [CHAR_W-1:0] ctrl_q;
  logic [CHAR_W-1:0] stat;
  logic              wr_data, rd_data, flush;

  assign wr_data = bus_wr && (bus_addr == ADR_DATA);
  assign rd_data = bus_rd && (bus_addr == ADR_DATA);
  assign flush   = bus_wr && (bus_addr == ADR_FLUSH) && (bus_wdata == '0);

  uart_fifo #(.W(CHAR_W), .DEPTH(DEPTH)) u_txq (
    .clk   (clk),
    .rst   (rst),
    .clr   (1'b0),
    .push  (wr_data),
    .pop   (tx_take),
    .din   (bus_wdata),
    .dout  (tx_data),
    .empty (tx_empty),
    .full  (tx_full),
    .level (tx_lvl)
  );

  assign tx_avail = !tx_empty;

  uart_rx_path #(.DEPTH(DEPTH)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .rx_stb  (rx_stb),
    .rx_char (rx_char),
    .rx_perr (rx_perr),
    .rx_ferr (rx_ferr),
    .rx_brk  (rx_brk),
    .flush   (flush),
    .pop     (rd_data),
    .head    (rx_head),
    .empty   (rx_empty),
    .level   (rx_lvl)
  );

  // status byte: queue states plus the flags of the oldest received char
  always_comb begin
    stat              = '0;
    stat[ST_TX_ROOM]  = !tx_full;
    stat[ST_RX_AVAIL] = !rx_empty;
    stat[ST_TX_DONE]  = tx_empty && tx_idle;
    if (!rx_empty) begin
      stat[ST_BRK] = rx_head.brk;
      stat[ST_OVR] = rx_head.ovr;
      stat[ST_FRM] = rx_head.frm && !rx_head.brk;
      stat[ST_PAR] = rx_head.par && !rx_head.brk;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (bus_wr && (bus_addr == ADR_LCTL)) begin
      ctrl_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      unique case (bus_addr)
        ADR_DATA: bus_rdata <= rx_empty ? '0 : rx_head.ch;
        ADR_STAT: bus_rdata <= stat;
        ADR_LCTL: bus_rdata <= ctrl_q;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ser_out <= 1'b1;
    else     ser_out <= ctrl_q[LC_FORCE_BRK] ? 1'b0 : ser_in;
  end

endmodule

// File: rtl/uart_lsr_chk.sv
module uart_lsr_chk
  import uart_lsr_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CHAR_W-1:0] bus_wdata,
  input logic [CHAR_W-1:0] bus_rdata,
  input logic              tx_take,
  input logic              tx_full,
  input logic [CW-1:0]     tx_lvl,
  input logic [CW-1:0]     rx_lvl,
  input logic [CHAR_W-1:0] ctrl_q,
  input logic              ser_out
);

  localparam logic [CW-1:0] MAX_LVL = CW'(DEPTH);

  AST_TX_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADR_DATA && tx_full && !tx_take) |=> (tx_lvl == $past(tx_lvl))); // R3

  AST_RX_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADR_FLUSH && bus_wdata == '0) |=> (rx_lvl == '0)); // R9

  AST_BRK_MASK: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADR_STAT) |=>
      !(bus_rdata[ST_BRK] && (bus_rdata[ST_FRM] || bus_rdata[ST_PAR]))); // R7

  AST_TX_DONE_LOW: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADR_STAT && tx_lvl != '0) |=> !bus_rdata[ST_TX_DONE]); // R4

  AST_NO_ROOM_BIT: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADR_STAT && tx_full) |=> !bus_rdata[ST_TX_ROOM]); // R2

  AST_BREAK_LINE: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[LC_FORCE_BRK] |=> !ser_out); // R10

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    (tx_lvl <= MAX_LVL) && (rx_lvl <= MAX_LVL)); // R2

endmodule

bind uart_lsr_top uart_lsr_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_uart_lsr_top.sv
`timescale 1ns/1ps
module tb_uart_lsr_top;

  localparam int DEPTH = 128;

  logic       clk = 1'b0;
  logic       rst;
  logic       bus_wr, bus_rd;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [7:0] tx_data;
  logic       tx_avail, tx_take, tx_idle, ser_in, ser_out;
  logic       rx_stb, rx_perr, rx_ferr, rx_brk;
  logic [7:0] rx_char;

  always #2.5 clk = ~clk;

  uart_lsr_top #(.DEPTH(DEPTH)) dut (.*);

  int n_chk = 0;
  int n_bad = 0;

  // bench model; rx entry: [11] brk [10] frm [9] par [8] ovr [7:0] char
  logic [7:0]  tq[$];
  logic [11:0] rq[$];
  logic        m_pend = 1'b0;
  logic [7:0]  m_ctrl = 8'h00;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_stat();
    logic [7:0]  s = '0;
    logic [11:0] e;
    s[0] = tq.size() < DEPTH;
    s[1] = rq.size() != 0;
    if (rq.size() != 0) begin
      e    = rq[0];
      s[5] = e[11];
      s[4] = e[10] && !e[11];
      s[2] = e[9] && !e[11];
      s[3] = e[8];
    end
    s[6] = (tq.size() == 0) && tx_idle;
    return s;
  endfunction

  task automatic cyc();
    @(posedge clk);
    #1;
    bus_wr = 0; bus_rd = 0; rx_stb = 0; tx_take = 0;
  endtask

  task automatic bwrite(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    cyc();
    case (a)
      2'd0: if (tq.size() < DEPTH) tq.push_back(d);
      2'd2: m_ctrl = d;
      2'd3: if (d == 8'h00) begin rq.delete(); m_pend = 1'b0; end
      default: ;
    endcase
  endtask

  task automatic bread(input string req, input logic [1:0] a);
    logic [7:0] exp;
    case (a)
      2'd0: begin
        exp = (rq.size() != 0) ? rq[0][7:0] : 8'h00;
        if (rq.size() != 0) void'(rq.pop_front());
      end
      2'd1: exp = exp_stat();
      2'd2: exp = m_ctrl;
      default: exp = 8'h00;
    endcase
    bus_rd = 1; bus_addr = a;
    cyc();
    chk(req, {24'd0, bus_rdata}, {24'd0, exp});
  endtask

  task automatic rx_in(input logic [7:0] c, input logic p, input logic f, input logic b);
    rx_stb = 1; rx_char = c; rx_perr = p; rx_ferr = f; rx_brk = b;
    cyc();
    if (rq.size() == DEPTH) m_pend = 1'b1;
    else begin rq.push_back({b, f, p, m_pend, c}); m_pend = 1'b0; end
  endtask

  task automatic tx_take1(input string req);
    chk(req, {31'd0, tx_avail}, {31'd0, tq.size() != 0});
    if (tq.size() != 0) begin
      chk(req, {24'd0, tx_data}, {24'd0, tq[0]});
      tx_take = 1;
      cyc();
      void'(tq.pop_front());
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] held;
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; tx_take = 0; tx_idle = 1;
    ser_in = 1; rx_stb = 0; rx_char = 0; rx_perr = 0; rx_ferr = 0; rx_brk = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;

    // R1 reset state
    bread("R1", 2'd1);
    chk("R1", {24'd0, bus_rdata}, 32'h41);
    bread("R1", 2'd2);
    ser_in = 0; cyc(); cyc();
    chk("R1", {31'd0, ser_out}, 32'd0);
    ser_in = 1; cyc(); cyc();
    chk("R1", {31'd0, ser_out}, 32'd1);
    bread("R5", 2'd0);

    // R2 fill transmit queue, R3 overflow write ignored
    for (int i = 0; i < DEPTH; i++) bwrite(2'd0, 8'(i * 3 + 1));
    bread("R2", 2'd1);
    chk("R2", {31'd0, bus_rdata[0]}, 32'd0);
    bwrite(2'd0, 8'hEE);
    for (int i = 0; i < DEPTH; i++) tx_take1("R3");
    chk("R3", {31'd0, tx_avail}, 32'd0);

    // R4 drained bit needs idle shifter
    tx_idle = 0;
    bread("R4", 2'd1);
    tx_idle = 1;
    bwrite(2'd0, 8'h5A);
    bread("R4", 2'd1);
    tx_take1("R2");
    bread("R4", 2'd1);

    // R6 R7 head flags
    rx_in(8'h11, 1, 0, 0);
    rx_in(8'h22, 1, 1, 1);
    rx_in(8'h33, 0, 1, 0);
    bread("R6", 2'd1); bread("R5", 2'd0);
    bread("R7", 2'd1);
    chk("R7", {24'd0, bus_rdata}, 32'h63);
    bread("R5", 2'd0);
    bread("R6", 2'd1); bread("R5", 2'd0);
    bread("R6", 2'd1);

    // R8 overrun
    for (int i = 0; i < DEPTH; i++) rx_in(8'(i + 7), 0, 0, 0);
    rx_in(8'h99, 0, 0, 0);
    for (int i = 0; i < DEPTH; i++) bread("R8", 2'd0);
    rx_in(8'h55, 0, 0, 0);
    bread("R8", 2'd1);
    chk("R8", {31'd0, bus_rdata[3]}, 32'd1);
    bread("R8", 2'd0);

    // R9 flush
    for (int i = 0; i < 5; i++) rx_in(8'(i + 40), 0, 0, 0);
    bwrite(2'd3, 8'h01);
    bread("R9", 2'd1);
    chk("R9", {31'd0, bus_rdata[1]}, 32'd1);
    bwrite(2'd3, 8'h00);
    bread("R9", 2'd1);
    chk("R9", {31'd0, bus_rdata[1]}, 32'd0);
    for (int i = 0; i <= DEPTH; i++) rx_in(8'(i), 0, 0, 0);
    bwrite(2'd3, 8'h00);
    rx_in(8'h66, 0, 0, 0);
    bread("R9", 2'd1);
    chk("R9", {31'd0, bus_rdata[3]}, 32'd0);
    bread("R9", 2'd0);

    // R10 break control
    bwrite(2'd2, 8'h20);
    bread("R10", 2'd2);
    chk("R10", {31'd0, ser_out}, 32'd0);
    bwrite(2'd2, 8'h00);
    cyc();
    chk("R10", {31'd0, ser_out}, 32'd1);

    // R11 read data holds
    rx_in(8'hA7, 0, 0, 0);
    bread("R11", 2'd0);
    held = bus_rdata;
    repeat (4) cyc();
    chk("R11", {24'd0, bus_rdata}, {24'd0, held});

    // random mix
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      int unsigned op;
      op = $urandom_range(0, 9);
      tx_idle = ($urandom_range(0, 3) != 0);
      case (op)
        0, 1: bwrite(2'd0, 8'($urandom));
        2:    tx_take1("R2");
        3, 4: rx_in(8'($urandom), $urandom_range(0, 4) == 0,
                    $urandom_range(0, 4) == 0, $urandom_range(0, 6) == 0);
        5:    bread("R5", 2'd0);
        6, 7: bread("R6", 2'd1);
        8:    bread("R10", 2'd2);
        default: bwrite(2'd3, ($urandom_range(0, 7) == 0) ? 8'h00 : 8'h04);
      endcase
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

endmodule